// File: doc/BRIEF.md
# Wake-Up Source Controller

This block sits beside a power sequencer and decides when the chip must leave a low-power state. It watches a set of dedicated asynchronous wake pins and a bus of synchronous peripheral interrupt lines. Each pin is synchronized, optionally inverted, and tested against a per-pin trigger selection (rising edge, falling edge, both edges, high level, low level). A pin event counts only if the pin is enabled and the current low-power mode allows that pin to wake the chip. Each qualifying pin event sets a sticky status bit. A peripheral interrupt counts only if its mask bit is set and the core reports that it is idle.

Any qualifying event raises a single wake request that carries a source number. The request and its number stay fixed until the sequencer acknowledges them. Software configures the block through a small word-addressed register port with registered read data.

Top module: `wake_src_ctrl`

## Requirements
- R1: After synchronous reset, every register reads zero, `wake_req_o` is 0 and `wake_src_o` is 0.
- R2: The register map uses word addresses: 0 = pin enable, 1 = polarity, 2 = status, 3 = interrupt wake mask, 4 and 5 = trigger bytes. Address 4 holds pins 0..3 and address 5 holds pins 4..7, with pin n in byte n mod 4. Read data appears one cycle after the address. Unused bits and unused addresses read zero.
- R3: Trigger byte codes: 0x01 fires on a rising edge, 0x02 on a falling edge, 0x03 on either edge, 0x04 while high, 0x08 while low. Set bits combine as an OR, and 0x00 never fires.
- R4: A trigger byte with any bit set in 0xF0 disables that pin entirely.
- R5: A polarity bit of 1 inverts the synchronized pin before edge and level tests.
- R6: A pin whose enable bit is 0 never sets status and never raises a request.
- R7: Status bits are sticky. Writing 1 to a status bit clears it. A new event in the same cycle wins over the clear.
- R8: Mode input encoding: 0 = run, 1 = deep sleep, 2 = hibernate, 3 = run. In run mode no pin qualifies. In deep sleep, pins 0..6 qualify and pin 7 does not. In hibernate, all pins qualify.
- R9: A peripheral interrupt qualifies only when its mask bit is 1 and `core_idle_i` is 1. It is reported with source number 8 (the pin count).
- R10: When several events qualify in the same cycle, the lowest-numbered pin is reported. Any pin wins over an interrupt.
- R11: `wake_req_o` and `wake_src_o` hold until `wake_ack_i` is seen while the request is high. The request then drops on the next clock.
- R12: A pin change driven before clock edge k raises `wake_req_o` after edge k+2. This covers two synchronizer flops and the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin_i | input | 8 | Asynchronous wake pins |
| irq_i | input | 16 | Synchronous peripheral interrupt lines |
| core_idle_i | input | 1 | Core is idled |
| lp_mode_i | input | 2 | Current low-power mode (R8 encoding) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| wake_req_o | output | 1 | Wake request to sequencer |
| wake_src_o | output | 4 | Number of the source that caused the request |
| wake_ack_i | input | 1 | Sequencer acknowledge |

## Verification
Wrong stored state inside this block shows up at the ports in one of two ways.

- A corrupted previous-sample flop or synchronizer stage produces a spurious edge or a missing edge. This appears as a wrong request or a wrong status bit three clocks after the pin moves.
- A bad trigger, enable or mask register shows up in the next read of that address, one cycle after the address is presented. It also shows up as a request that never comes.

A mis-held request register shows as a changed source number, or a dropped request, on the very next clock.

// File: rtl/wake_src_pkg.sv
package wake_src_pkg;

  typedef enum logic [1:0] {
    LP_RUN  = 2'b00,
    LP_DEEP = 2'b01,
    LP_HIB  = 2'b10,
    LP_RSVD = 2'b11
  } lp_mode_e;

  // trigger byte bit positions
  localparam int TB_RISE = 0;
  localparam int TB_FALL = 1;
  localparam int TB_HIGH = 2;
  localparam int TB_LOW  = 3;
  localparam logic [7:0] TRIG_KILL_MASK = 8'hF0;

  // register word indices
  localparam int RG_ENABLE    = 0;
  localparam int RG_POLARITY  = 1;
  localparam int RG_STATUS    = 2;
  localparam int RG_IRQMASK   = 3;
  localparam int RG_TRIG_BASE = 4;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wake_src_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  logic       pol_i,
  input  logic [7:0] trig_i,
  input  logic       en_i,
  input  logic       allow_i,
  output logic       hit_o
);

  logic prev_q;
  logic cur_lvl, old_lvl, armed, cond;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  // polarity applied to both samples so a polarity change makes no edge
  assign cur_lvl = sync_i ^ pol_i;
  assign old_lvl = prev_q ^ pol_i;
  assign armed   = en_i & allow_i & ~(|(trig_i & TRIG_KILL_MASK));
  assign cond    = (trig_i[TB_RISE] &  cur_lvl & ~old_lvl) |
                   (trig_i[TB_FALL] & ~cur_lvl &  old_lvl) |
                   (trig_i[TB_HIGH] &  cur_lvl) |
                   (trig_i[TB_LOW]  & ~cur_lvl);
  assign hit_o   = armed & cond;

endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_src_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_IRQ  = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_PINS-1:0]        set_i,
  output logic [NUM_PINS-1:0]        en_o,
  output logic [NUM_PINS-1:0]        pol_o,
  output logic [NUM_IRQ-1:0]         mask_o,
  output logic [NUM_PINS-1:0][7:0]   trig_o,
  output logic [NUM_PINS-1:0]        status_o,
  output logic [DATA_W-1:0]          rdata_o
);

  localparam int BPW        = DATA_W / 8;
  localparam int TRIG_WORDS = (NUM_PINS + BPW - 1) / BPW;
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(RG_ENABLE);
  localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(RG_POLARITY);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(RG_STATUS);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(RG_IRQMASK);

  logic [NUM_PINS-1:0]          en_q, pol_q, status_q, clr;
  logic [NUM_IRQ-1:0]           mask_q;
  logic [NUM_PINS-1:0][7:0]     trig_q;
  logic [TRIG_WORDS*DATA_W-1:0] trig_flat;
  logic [DATA_W-1:0]            rd_next, rdata_q;

  genvar g;
  generate
    for (g = 0; g < TRIG_WORDS * BPW; g++) begin : g_flat
      if (g < NUM_PINS) begin : g_used
        assign trig_flat[g*8 +: 8] = trig_q[g];
      end else begin : g_pad
        assign trig_flat[g*8 +: 8] = 8'h00;
      end
    end
  endgenerate

  assign clr = (we_i && addr_i == A_ST) ? wdata_i[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      pol_q    <= '0;
      mask_q   <= '0;
      trig_q   <= '0;
      status_q <= '0;
    end else begin
      if (we_i && addr_i == A_EN)  en_q   <= wdata_i[NUM_PINS-1:0];
      if (we_i && addr_i == A_POL) pol_q  <= wdata_i[NUM_PINS-1:0];
      if (we_i && addr_i == A_MSK) mask_q <= wdata_i[NUM_IRQ-1:0];
      for (int i = 0; i < NUM_PINS; i++) begin
        if (we_i && addr_i == ADDR_W'(RG_TRIG_BASE + i / BPW))
          trig_q[i] <= wdata_i[(i % BPW)*8 +: 8];
      end
      status_q <= (status_q & ~clr) | set_i;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      A_EN:    rd_next[NUM_PINS-1:0] = en_q;
      A_POL:   rd_next[NUM_PINS-1:0] = pol_q;
      A_ST:    rd_next[NUM_PINS-1:0] = status_q;
      A_MSK:   rd_next[NUM_IRQ-1:0]  = mask_q;
      default: begin
        for (int w = 0; w < TRIG_WORDS; w++) begin
          if (addr_i == ADDR_W'(RG_TRIG_BASE + w))
            rd_next = trig_flat[w*DATA_W +: DATA_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign en_o     = en_q;
  assign pol_o    = pol_q;
  assign mask_o   = mask_q;
  assign trig_o   = trig_q;
  assign status_o = status_q;
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
  parameter int NUM_PINS = 8,
  parameter int SRC_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic                irq_hit_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic [SRC_W-1:0]    src_o
);

  logic             req_q;
  logic [SRC_W-1:0] src_q, sel;
  logic             any;

  always_comb begin
    sel = SRC_W'(NUM_PINS);
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (hit_i[i]) sel = SRC_W'(i);
    end
  end

  assign any = (|hit_i) | irq_hit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      src_q <= '0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (any) begin
      req_q <= 1'b1;
      src_q <= sel;
    end
  end

  assign req_o = req_q;
  assign src_o = src_q;

endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
  import wake_src_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int NUM_IRQ     = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] HIB_ONLY_MASK = {1'b1, {(NUM_PINS-1){1'b0}}},
  localparam int SRC_W = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] wake_pin_i,
  input  logic [NUM_IRQ-1:0]  irq_i,
  input  logic                core_idle_i,
  input  logic [1:0]          lp_mode_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                wake_req_o,
  output logic [SRC_W-1:0]    wake_src_o,
  input  logic                wake_ack_i
);

  logic [NUM_PINS-1:0]      sync_pins, hit, allow, en, pol, status_q;
  logic [NUM_IRQ-1:0]       mask;
  logic [NUM_PINS-1:0][7:0] trig;
  logic                     irq_hit, in_deep, in_hib;

  wake_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(wake_pin_i), .q_o(sync_pins)
  );

  wake_regs #(
    .NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .set_i(hit), .en_o(en), .pol_o(pol),
    .mask_o(mask), .trig_o(trig), .status_o(status_q), .rdata_o(reg_rdata_o)
  );

  assign in_deep = (lp_mode_i == LP_DEEP);
  assign in_hib  = (lp_mode_i == LP_HIB);
  assign allow   = {NUM_PINS{in_hib}} | ({NUM_PINS{in_deep}} & ~HIB_ONLY_MASK);

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_det
      wake_detect u_det (
        .clk(clk), .rst(rst), .sync_i(sync_pins[g]), .pol_i(pol[g]),
        .trig_i(trig[g]), .en_i(en[g]), .allow_i(allow[g]), .hit_o(hit[g])
      );
    end
  endgenerate

  assign irq_hit = core_idle_i & (|(irq_i & mask));

  wake_arbiter #(.NUM_PINS(NUM_PINS), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst(rst), .hit_i(hit), .irq_hit_i(irq_hit),
    .ack_i(wake_ack_i), .req_o(wake_req_o), .src_o(wake_src_o)
  );

endmodule

// File: rtl/wake_src_ctrl_chk.sv
module wake_src_ctrl_chk #(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 4,
  parameter int SRC_W    = 4,
  parameter logic [NUM_PINS-1:0] HIB_ONLY_MASK = '0
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          lp_mode_i,
  input logic                core_idle_i,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic                wake_req_o,
  input logic [SRC_W-1:0]    wake_src_o,
  input logic                wake_ack_i,
  input logic [NUM_PINS-1:0] status_q
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !wake_req_o);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_req_o && !wake_ack_i) |=> (wake_req_o && $stable(wake_src_o)));

  // R11
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_req_o && wake_ack_i) |=> !wake_req_o);

  // R10
  src_range_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> (wake_src_o <= SRC_W'(NUM_PINS)));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_q) & ~status_q)) |->
      $past(reg_we_i && reg_addr_i == ADDR_W'(2)));

  // R8
  hib_only_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & ~$past(status_q) & HIB_ONLY_MASK)) |-> ($past(lp_mode_i) == 2'b10));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake_req_o) && wake_src_o == SRC_W'(NUM_PINS)) |-> $past(core_idle_i));

endmodule

bind wake_src_ctrl wake_src_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .SRC_W(SRC_W), .HIB_ONLY_MASK(HIB_ONLY_MASK)
) u_chk (
  .clk(clk), .rst(rst), .lp_mode_i(lp_mode_i), .core_idle_i(core_idle_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .wake_req_o(wake_req_o),
  .wake_src_o(wake_src_o), .wake_ack_i(wake_ack_i), .status_q(status_q)
);

// File: tb/wake_src_ctrl_bench.sv
module wake_src_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = '0;
  logic [15:0] irq = '0;
  logic        idle = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic [3:0]  src;
  logic        ack = 1'b0;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  wake_src_ctrl u_wake_src_ctrl (
    .clk(clk), .rst(rst), .wake_pin_i(pins), .irq_i(irq), .core_idle_i(idle),
    .lp_mode_i(mode), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wake_req_o(req), .wake_src_o(src), .wake_ack_i(ack)
  );

  // behavioural reference model
  bit [7:0]  m_en, m_pol, m_st, m_s1, m_s2, m_prev;
  bit [15:0] m_mask;
  bit [7:0]  m_trig [8];
  bit [31:0] m_rd;
  bit        m_req;
  int        m_src;

  function automatic bit pin_fires(int i);
    bit a, p;
    bit [7:0] t;
    t = m_trig[i];
    a = m_s2[i] ^ m_pol[i];
    p = m_prev[i] ^ m_pol[i];
    if ((t & 8'hF0) != 0 || !m_en[i]) return 0;
    if (mode == 2'd1 && i == 7) return 0;
    if (mode != 2'd1 && mode != 2'd2) return 0;
    return (t[0] && a && !p) || (t[1] && !a && p) || (t[2] && a) || (t[3] && !a);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_pol = 0; m_st = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_mask = 0; m_rd = 0; m_req = 0; m_src = 0;
      foreach (m_trig[i]) m_trig[i] = 0;
    end else begin
      bit [7:0] ev;
      bit irq_ev;
      int first;
      ev = 0;
      for (int i = 0; i < 8; i++) ev[i] = pin_fires(i);
      irq_ev = idle && ((irq & m_mask) != 0);
      case (addr)
        4'd0: m_rd = {24'd0, m_en};
        4'd1: m_rd = {24'd0, m_pol};
        4'd2: m_rd = {24'd0, m_st};
        4'd3: m_rd = {16'd0, m_mask};
        4'd4: m_rd = {m_trig[3], m_trig[2], m_trig[1], m_trig[0]};
        4'd5: m_rd = {m_trig[7], m_trig[6], m_trig[5], m_trig[4]};
        default: m_rd = 0;
      endcase
      if (we && addr == 4'd2) m_st = m_st & ~wdata[7:0];
      m_st = m_st | ev;
      if (we) begin
        case (addr)
          4'd0: m_en = wdata[7:0];
          4'd1: m_pol = wdata[7:0];
          4'd3: m_mask = wdata[15:0];
          4'd4: for (int b = 0; b < 4; b++) m_trig[b] = wdata[b*8 +: 8];
          4'd5: for (int b = 0; b < 4; b++) m_trig[4+b] = wdata[b*8 +: 8];
          default: ;
        endcase
      end
      if (m_req) begin
        if (ack) m_req = 0;
      end else if (ev != 0 || irq_ev) begin
        first = 8;
        for (int i = 7; i >= 0; i--) if (ev[i]) first = i;
        m_req = 1;
        m_src = first;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks += 3;
      if (req !== m_req) begin
        errors++;
        $display("FAIL %s model: wake_req act=%0b exp=%0b", cur_req, req, m_req);
      end
      if (src !== 4'(m_src)) begin
        errors++;
        $display("FAIL %s model: wake_src act=%0d exp=%0d", cur_req, src, m_src);
      end
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL %s model: rdata act=%h exp=%h", cur_req, rdata, m_rd);
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pins = '0; irq = '0; idle = 1'b0;
    mode = 2'd0; ack = 1'b0; we = 1'b0; addr = '0;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    report();
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    cur_req = "R1";
    chk("R1 req", {31'd0, req}, 0);
    chk("R1 src", {28'd0, src}, 0);
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), v);
      chk("R1 reg", v, 0);
    end

    // R2 map, unused bits and addresses
    cur_req = "R2";
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R2 enable", v, 32'h0000_00FF);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, v); chk("R2 mask", v, 32'h0000_FFFF);
    wr(4'd5, 32'hA5C3_0F10); rd(4'd5, v); chk("R2 trig hi", v, 32'hA5C3_0F10);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, v); chk("R2 unused addr", v, 0);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R2 status", v, 0);

    // R12 latency, R11 hold, R7 clear
    do_reset();
    cur_req = "R12";
    mode = 2'd1;
    wr(4'd4, 32'h0000_0001);
    wr(4'd0, 32'h0000_0001);
    @(negedge clk); pins[0] = 1'b1;
    cyc(2); chk("R12 not yet", {31'd0, req}, 0);
    cyc(1); chk("R12 req", {31'd0, req}, 1); chk("R12 src", {28'd0, src}, 0);
    cur_req = "R11";
    cyc(4); chk("R11 held", {31'd0, req}, 1);
    pulse_ack(); chk("R11 dropped", {31'd0, req}, 0);
    cur_req = "R7";
    rd(4'd2, v); chk("R7 sticky", v, 32'h01);
    wr(4'd2, 32'h01); rd(4'd2, v); chk("R7 w1c", v, 0);

    // R3 falling edge on pin 1
    cur_req = "R3";
    wr(4'd4, 32'h0000_0201);
    wr(4'd0, 32'h0000_0003);
    @(negedge clk); pins[1] = 1'b1;
    cyc(4); rd(4'd2, v); chk("R3 no fire on rise", v, 0);
    @(negedge clk); pins[1] = 1'b0;
    cyc(4); rd(4'd2, v); chk("R3 fall", v, 32'h02);
    chk("R3 src", {28'd0, src}, 1);
    pulse_ack();
    wr(4'd4, 32'h0000_0300);
    @(negedge clk); pins[1] = 1'b1;
    cyc(4); chk("R3 both edges", {28'd0, src}, 1);
    pulse_ack();

    // R4 kill bits, R5 polarity, R6 enable
    do_reset();
    cur_req = "R5";
    mode = 2'd1;
    wr(4'd5, 32'h0000_0400);
    wr(4'd1, 32'h0000_0008);
    wr(4'd4, 32'h0414_0000);
    @(negedge clk); pins[2] = 1'b1; pins[5] = 1'b1;
    wr(4'd0, 32'h0000_000C);
    cyc(4);
    rd(4'd2, v); chk("R4 R5 R6 status", v, 32'h08);
    chk("R5 src", {28'd0, src}, 3);
    cur_req = "R7";
    wr(4'd2, 32'h08); rd(4'd2, v); chk("R7 set beats clear", v, 32'h08);

    // R8 mode qualification
    do_reset();
    cur_req = "R8";
    mode = 2'd1;
    wr(4'd5, 32'h0400_0000);
    wr(4'd0, 32'h0000_0080);
    @(negedge clk); pins[7] = 1'b1;
    cyc(5); rd(4'd2, v); chk("R8 deep", v, 0);
    mode = 2'd0;
    cyc(5); rd(4'd2, v); chk("R8 run", v, 0);
    chk("R8 no req", {31'd0, req}, 0);
    mode = 2'd2;
    cyc(4); rd(4'd2, v); chk("R8 hib", v, 32'h80);
    chk("R8 src", {28'd0, src}, 7);

    // R9 interrupt wake
    do_reset();
    cur_req = "R9";
    wr(4'd3, 32'h0000_0004);
    @(negedge clk); irq = 16'h0001; idle = 1'b1;
    cyc(3); chk("R9 masked", {31'd0, req}, 0);
    irq = 16'h0004; idle = 1'b0;
    cyc(3); chk("R9 not idle", {31'd0, req}, 0);
    idle = 1'b1;
    cyc(2); chk("R9 req", {31'd0, req}, 1); chk("R9 src", {28'd0, src}, 8);
    pulse_ack();

    // R10 priority
    do_reset();
    cur_req = "R10";
    mode = 2'd1;
    wr(4'd4, 32'h0404_0404);
    wr(4'd5, 32'h0404_0404);
    wr(4'd3, 32'h0000_0001);
    wr(4'd0, 32'h0000_00FF);
    @(negedge clk); pins[2] = 1'b1; pins[5] = 1'b1;
    cyc(2); irq = 16'h0001; idle = 1'b1;
    cyc(1); chk("R10 req", {31'd0, req}, 1); chk("R10 lowest pin", {28'd0, src}, 2);
    pulse_ack();
    cyc(2); rd(4'd2, v); chk("R10 status", v, 32'h24);
    cyc(2);

    report();
  end

endmodule